// File: doc/BRIEF.md
# Color Palette Host Register Port

This block is the host side of a 256-entry color palette of the kind that sits in front of a video DAC. A 32-bit bus master loads and inspects the palette through three ports: a pointer port, a palette data port and an indirect control port. Every byte-wide quantity rides in the top byte (bits 31:24) of the bus word. The display pipeline reads the palette through its own port, which takes an 8-bit pixel value and returns 24-bit RGB.

Loading is sequential. An internal entry pointer selects the entry. A component sequencer then walks red, green and blue. The sequencer has three states: COMP_RED, COMP_GRN and COMP_BLU. It has three transitions:
- STEP moves from COMP_RED to COMP_GRN, or from COMP_GRN to COMP_BLU, on a palette data access.
- ROLL moves from COMP_BLU back to COMP_RED on a palette data access and advances the pointer.
- RESTART forces COMP_RED whenever the pointer port is written.

One stored control value sits behind pointer value 0x06. When both of its bits are set, the cursor enable output goes high.

Top module: `palette_host_port`

## Requirements
- R1: After reset the pointer is 0, the sequencer is in COMP_RED, the stored control bits are 0, and `cursor_en`, `bus_rdata` and `pix_rgb` are all 0.
- R2: `bus_port` selects the port: 0 = pointer, 1 = palette data, 2 = control, 3 = unused. A write to the pointer port loads the pointer from bits 31:24 and returns the sequencer to COMP_RED.
- R3: A palette data write stores bits 31:24 into the current component of the pointed entry and ignores bits 23:0. Successive data accesses fill red, then green, then blue, and the blue access advances the pointer by one.
- R4: The pointer advances from 255 to 0 after the blue access of entry 255.
- R5: A palette data read returns the current component in bits 31:24, with bits 23:0 zero, on `bus_rdata` in the cycle after the strobe. It advances the sequencer and the pointer exactly as a write does.
- R6: A read of the pointer port returns the pointer in bits 31:24, with bits 23:0 zero, in the cycle after the strobe, and does not move the sequencer.
- R7: A control port write while the pointer equals 6 stores bits 25:24. While the pointer differs from 6, a control write is ignored. `cursor_en` is high exactly when both stored bits are 1. A control read returns the stored bits in 25:24 when the pointer is 6, and zero otherwise.
- R8: `pix_rgb` returns {red, green, blue} of the entry at `pix_idx`, with red in bits 23:16 and blue in bits 7:0, one cycle after `pix_idx` is presented.
- R9: A pixel lookup in the same cycle as a palette write to the same entry returns the value from before the write. The new value is seen one cycle later.
- R10: When `bus_wr` and `bus_rd` are both high, only the write takes effect. `bus_rdata` holds its value and the sequencer advances once.
- R11: Writes to port 3 change no state. Reads of port 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_port | input | 2 | Port select (0 pointer, 1 data, 2 control, 3 unused) |
| bus_wdata | input | 32 | Write data; the byte value is in bits 31:24 |
| bus_rdata | output | 32 | Read data, registered; holds until the next read |
| pix_idx | input | 8 | Pixel value used as palette index |
| pix_rgb | output | 24 | Palette color for the index presented one cycle earlier |
| cursor_en | output | 1 | High when both stored control bits are set |

## Verification
The display lookup and a host palette write can address the same entry in the same cycle. The bench provokes this by presenting an entry's index on `pix_idx` in the very cycle that the blue byte of that entry is written. It expects the old blue in that cycle's result and the new blue one cycle later. A write strobe and a read strobe can also coincide. That case is judged by checking that `bus_rdata` is unchanged, that the written byte lands, and that the pointer moved only once.

// File: rtl/palette_pkg.sv
package palette_pkg;

    localparam int NUM_LANES = 3;

    typedef enum logic [1:0] {
        COMP_RED = 2'd0,
        COMP_GRN = 2'd1,
        COMP_BLU = 2'd2
    } comp_e;

    typedef enum logic [1:0] {
        PORT_PTR  = 2'd0,
        PORT_DATA = 2'd1,
        PORT_CTRL = 2'd2,
        PORT_NONE = 2'd3
    } port_e;

endpackage

// File: rtl/palette_seq.sv
module palette_seq
    import palette_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_load,
    input  logic [IDX_W-1:0] ptr_value,
    input  logic             data_step,
    output logic [IDX_W-1:0] ptr,
    output comp_e            comp
);

    comp_e            comp_q, comp_d;
    logic             roll;
    logic [IDX_W-1:0] ptr_q;

    // next-state logic: STEP, ROLL, RESTART
    always_comb begin
        comp_d = comp_q;
        roll   = 1'b0;
        if (ptr_load) begin
            comp_d = COMP_RED;                  // RESTART
        end else if (data_step) begin
            unique case (comp_q)
                COMP_RED: comp_d = COMP_GRN;    // STEP
                COMP_GRN: comp_d = COMP_BLU;    // STEP
                COMP_BLU: begin
                    comp_d = COMP_RED;          // ROLL
                    roll   = 1'b1;
                end
                default:  comp_d = COMP_RED;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) comp_q <= COMP_RED;
        else        comp_q <= comp_d;
    end

    // pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr_q <= '0;
        else if (ptr_load) ptr_q <= ptr_value;
        else if (roll)     ptr_q <= ptr_q + 1'b1;
    end

    assign ptr  = ptr_q;
    assign comp = comp_q;

    AST_RESTART_RED: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_load |=> (comp_q == COMP_RED && ptr_q == $past(ptr_value))); // R2
    AST_RED_TO_GRN: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !ptr_load && comp_q == COMP_RED) |=> comp_q == COMP_GRN); // R3
    AST_GRN_TO_BLU: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !ptr_load && comp_q == COMP_GRN) |=> comp_q == COMP_BLU); // R3
    AST_ROLL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !ptr_load && comp_q == COMP_BLU && ptr_q != '1)
        |=> (comp_q == COMP_RED && ptr_q == IDX_W'($past(ptr_q) + 1'b1))); // R3
    AST_ROLL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_step && !ptr_load && comp_q == COMP_BLU && ptr_q == '1) |=> ptr_q == '0); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_step && !ptr_load) |=> ($stable(ptr_q) && $stable(comp_q))); // R6

endmodule

// File: rtl/palette_store.sv
module palette_store
    import palette_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  comp_e                     wr_comp,
    input  logic [CH_W-1:0]           wr_byte,
    input  logic [IDX_W-1:0]          host_idx,
    input  comp_e                     host_comp,
    output logic [CH_W-1:0]           host_byte,
    input  logic [IDX_W-1:0]          pix_idx,
    output logic [NUM_LANES*CH_W-1:0] pix_rgb
);

    localparam int DEPTH = 1 << IDX_W;

    logic [NUM_LANES-1:0][CH_W-1:0] host_lane;
    logic [NUM_LANES-1:0][CH_W-1:0] pix_lane;

    for (genvar c = 0; c < NUM_LANES; c++) begin : g_lane
        logic [CH_W-1:0] lane_mem [DEPTH];
        logic [CH_W-1:0] lane_pix_q;
        logic            lane_we;

        assign lane_we = wr_en && (wr_comp == comp_e'(c));

        always_ff @(posedge clk) begin
            if (lane_we) lane_mem[wr_idx] <= wr_byte;
        end

        // the lookup reads the array before this edge's write lands
        always_ff @(posedge clk) begin
            if (!rst_n) lane_pix_q <= '0;
            else        lane_pix_q <= lane_mem[pix_idx];
        end

        assign host_lane[c] = lane_mem[host_idx];
        // red goes to the top lane
        assign pix_lane[NUM_LANES-1-c] = lane_pix_q;
    end

    always_comb begin
        unique case (host_comp)
            COMP_RED: host_byte = host_lane[0];
            COMP_GRN: host_byte = host_lane[1];
            COMP_BLU: host_byte = host_lane[2];
            default:  host_byte = '0;
        endcase
    end

    assign pix_rgb = pix_lane;

    AST_PIX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && !wr_en && $stable(pix_idx)) |=> $stable(pix_rgb)); // R8

endmodule

// File: rtl/palette_ctrl.sv
module palette_ctrl #(
    parameter int IDX_W    = 8,
    parameter int CTRL_W   = 2,
    parameter int CTRL_IDX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [CTRL_W-1:0] wr_bits,
    output logic [CTRL_W-1:0] ctrl_bits,
    output logic              cursor_en
);

    logic              sel_hit;
    logic [CTRL_W-1:0] ctrl_q;

    assign sel_hit = (sel_idx == IDX_W'(CTRL_IDX));

    always_ff @(posedge clk) begin
        if (!rst_n)                  ctrl_q <= '0;
        else if (wr_en && sel_hit)   ctrl_q <= wr_bits;
    end

    assign ctrl_bits = ctrl_q;
    assign cursor_en = &ctrl_q;

    AST_CTRL_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_hit) |=> $stable(ctrl_q)); // R7
    AST_CTRL_HIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_hit) |=> ctrl_q == $past(wr_bits)); // R7

endmodule

// File: rtl/palette_host_port.sv
module palette_host_port
    import palette_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int IDX_W    = 8,
    parameter int CH_W     = 8,
    parameter int CTRL_W   = 2,
    parameter int CTRL_IDX = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [1:0]                bus_port,
    input  logic [BUS_W-1:0]          bus_wdata,
    output logic [BUS_W-1:0]          bus_rdata,
    input  logic [IDX_W-1:0]          pix_idx,
    output logic [NUM_LANES*CH_W-1:0] pix_rgb,
    output logic                      cursor_en
);

    localparam int LOW_W = BUS_W - CH_W;

    port_e             port_sel;
    logic              rd_take;
    logic              ptr_wr, data_wr, data_rd, ctrl_wr;
    logic [CH_W-1:0]   top_byte;
    logic [IDX_W-1:0]  ptr;
    comp_e             comp;
    logic [CH_W-1:0]   host_byte;
    logic [CTRL_W-1:0] ctrl_bits;
    logic [CH_W-1:0]   rd_byte;
    logic [BUS_W-1:0]  rdata_q;
    logic              low_lanes_unused;

    assign port_sel = port_e'(bus_port);
    assign top_byte = bus_wdata[BUS_W-1 -: CH_W];
    assign low_lanes_unused = ^bus_wdata[LOW_W-1:0];

    // a write wins over a read strobe in the same cycle
    assign rd_take = bus_rd && !bus_wr;
    assign ptr_wr  = bus_wr && (port_sel == PORT_PTR);
    assign data_wr = bus_wr && (port_sel == PORT_DATA);
    assign ctrl_wr = bus_wr && (port_sel == PORT_CTRL);
    assign data_rd = rd_take && (port_sel == PORT_DATA);

    palette_seq #(.IDX_W(IDX_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_load  (ptr_wr),
        .ptr_value (top_byte[CH_W-1 -: IDX_W]),
        .data_step (data_wr || data_rd),
        .ptr       (ptr),
        .comp      (comp)
    );

    palette_store #(.IDX_W(IDX_W), .CH_W(CH_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (data_wr),
        .wr_idx    (ptr),
        .wr_comp   (comp),
        .wr_byte   (top_byte),
        .host_idx  (ptr),
        .host_comp (comp),
        .host_byte (host_byte),
        .pix_idx   (pix_idx),
        .pix_rgb   (pix_rgb)
    );

    palette_ctrl #(.IDX_W(IDX_W), .CTRL_W(CTRL_W), .CTRL_IDX(CTRL_IDX)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_wr),
        .sel_idx   (ptr),
        .wr_bits   (top_byte[CTRL_W-1:0]),
        .ctrl_bits (ctrl_bits),
        .cursor_en (cursor_en)
    );

    always_comb begin
        unique case (port_sel)
            PORT_PTR:  rd_byte = CH_W'(ptr);
            PORT_DATA: rd_byte = host_byte;
            PORT_CTRL: rd_byte = (ptr == IDX_W'(CTRL_IDX)) ? CH_W'(ctrl_bits) : '0;
            default:   rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_take) rdata_q <= {rd_byte, {LOW_W{1'b0}}};
    end

    assign bus_rdata = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take |=> $stable(bus_rdata)); // R10
    AST_RDATA_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[LOW_W-1:0] == '0); // R5
    AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(cursor_en)); // R7

endmodule

// File: tb/palette_host_port_tb.sv
`timescale 1ns/1ps
module palette_host_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [1:0]  bus_port;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  pix_idx;
    logic [23:0] pix_rgb;
    logic        cursor_en;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // bench model
    logic [7:0] m_mem [256][3];
    logic [7:0] m_ptr;
    int         m_comp;
    logic [1:0] m_ctrl;

    always #2.5 clk = ~clk;

    palette_host_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_port(bus_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb), .cursor_en(cursor_en)
    );

    function automatic logic [23:0] exp_rgb(logic [7:0] i);
        return {m_mem[i][0], m_mem[i][1], m_mem[i][2]};
    endfunction

    function automatic logic [7:0] fill_byte(int i, int c);
        return 8'((i * 7 + c * 61 + 13) ^ (i >> 3));
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step();
        m_comp++;
        if (m_comp == 3) begin
            m_comp = 0;
            m_ptr  = m_ptr + 8'd1;
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic bus_cycle(bit wr, bit rd, logic [1:0] p, logic [31:0] d);
        bus_wr = wr; bus_rd = rd; bus_port = p; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic ptr_write(logic [7:0] v);
        bus_cycle(1, 0, 2'd0, {v, 24'($urandom())});
        m_ptr = v; m_comp = 0;
    endtask

    task automatic data_write(logic [7:0] b);
        bus_cycle(1, 0, 2'd1, {b, 24'($urandom())});
        m_mem[m_ptr][m_comp] = b;
        model_step();
    endtask

    task automatic data_read(string req);
        logic [31:0] e;
        e = {m_mem[m_ptr][m_comp], 24'h0};
        bus_cycle(0, 1, 2'd1, 32'h0);
        check(bus_rdata == e, req, bus_rdata, e);
        model_step();
    endtask

    task automatic ptr_read(string req);
        bus_cycle(0, 1, 2'd0, 32'h0);
        check(bus_rdata == {m_ptr, 24'h0}, req, bus_rdata, {m_ptr, 24'h0});
    endtask

    task automatic ctrl_write(logic [1:0] v);
        bus_cycle(1, 0, 2'd2, {6'($urandom()), v, 24'($urandom())});
        if (m_ptr == 8'd6) m_ctrl = v;
        check(cursor_en == (m_ctrl == 2'b11), "R7 cursor_en", 32'(cursor_en), 32'(m_ctrl == 2'b11));
    endtask

    task automatic pix_check(logic [7:0] i, string req);
        pix_idx = i;
        @(posedge clk);
        @(negedge clk);
        check(pix_rgb == exp_rgb(i), req, 32'(pix_rgb), 32'(exp_rgb(i)));
    endtask

    initial begin
        #1000000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        logic [23:0] old_rgb;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_port = 0; bus_wdata = 0; pix_idx = 0;
        m_ptr = 0; m_comp = 0; m_ctrl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        check(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
        check(cursor_en == 0, "R1 cursor_en", 32'(cursor_en), 0);
        check(pix_rgb == 0, "R1 pix_rgb", 32'(pix_rgb), 0);
        ptr_read("R1 pointer zero");

        // R3: fill everything from pointer 0; R4: ends wrapped to 0
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++)
                data_write(fill_byte(i, c));
        ptr_read("R4 wrap after full load");

        // R8: pixel lookups
        pix_check(8'd0, "R8 entry 0");
        pix_check(8'd255, "R8 entry 255");
        pix_check(8'd128, "R8 entry 128");

        // R2: pointer write restarts at red
        ptr_write(8'd10);
        data_write(8'hA1);
        ptr_write(8'd10);
        data_write(8'hB2);
        pix_check(8'd10, "R2 restart to red");

        // R5: reads walk components and advance
        ptr_write(8'd20);
        data_read("R5 read red");
        data_read("R5 read green");
        data_read("R5 read blue");
        ptr_read("R5 read advanced pointer");

        // R4: explicit wrap
        ptr_write(8'd255);
        data_write(8'h11); data_write(8'h22); data_write(8'h33);
        ptr_read("R4 wrap 255 to 0");
        pix_check(8'd255, "R4 entry 255 content");

        // R7: indirect control
        ptr_write(8'd6);
        ctrl_write(2'b11);
        bus_cycle(0, 1, 2'd2, 0);
        check(bus_rdata == 32'h0300_0000, "R7 ctrl read", bus_rdata, 32'h0300_0000);
        ctrl_write(2'b01);
        ptr_write(8'd7);
        ctrl_write(2'b11);
        bus_cycle(0, 1, 2'd2, 0);
        check(bus_rdata == 0, "R7 ctrl read off index", bus_rdata, 0);
        ptr_write(8'd6);
        bus_cycle(0, 1, 2'd2, 0);
        check(bus_rdata == 32'h0100_0000, "R7 ctrl kept", bus_rdata, 32'h0100_0000);

        // R9: lookup collides with blue write to the same entry
        ptr_write(8'd40);
        data_write(8'h5A); data_write(8'h6B);
        old_rgb = exp_rgb(8'd40);
        pix_idx = 8'd40;
        bus_cycle(1, 0, 2'd1, {8'hC7, 24'h123456});
        check(pix_rgb == old_rgb, "R9 old value in collision", 32'(pix_rgb), 32'(old_rgb));
        m_mem[40][2] = 8'hC7; model_step();
        @(posedge clk); @(negedge clk);
        check(pix_rgb == exp_rgb(8'd40), "R9 new value after", 32'(pix_rgb), 32'(exp_rgb(8'd40)));

        // R10: write and read strobes together
        ptr_write(8'd50);
        ptr_read("R10 setup");
        held = bus_rdata;
        bus_cycle(1, 1, 2'd1, {8'hE4, 24'h0});
        m_mem[50][0] = 8'hE4; model_step();
        check(bus_rdata == held, "R10 rdata held", bus_rdata, held);
        data_read("R10 single advance to green");
        pix_check(8'd50, "R10 write landed");

        // R11: unused port
        ptr_write(8'd60);
        bus_cycle(1, 0, 2'd3, 32'hFFFF_FFFF);
        ptr_read("R11 pointer untouched");
        data_read("R11 still at red");
        bus_cycle(0, 1, 2'd3, 0);
        check(bus_rdata == 0, "R11 read zero", bus_rdata, 0);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0: ptr_write(($urandom_range(0, 3) == 0) ? 8'd6 : 8'($urandom()));
                1: data_write(8'($urandom()));
                2: data_read("R5 random read");
                3: pix_check(8'($urandom()), "R8 random lookup");
                4: ctrl_write(2'($urandom()));
                default: ptr_read("R6 random pointer read");
            endcase
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule